// File: doc/BRIEF.md
# Register-write packet unpacker

This block sits between a command DMA engine and a register file. It takes a stream of 32-bit words and turns it into single register writes. The words arrive in packets of five: a header word, then four data words. The header packs four 8-bit register indices, one per byte.

Each index names a 32-bit register in one of two 512-byte windows. Bit 7 of the index picks the window and the low seven bits pick the word inside it. The block turns each index into a full 14-bit byte address. It then presents the writes one at a time on a valid/ready write port.

One index value marks a filler slot. Its data word is read from the stream and then thrown away. The input stream also uses valid/ready, and a stalled write holds back the input.

Top module: `regpkt_unpacker`

## Requirements
- R1: A packet is one header word followed by four data words. The word accepted right after the fourth data word is taken as the next header.
- R2: Header byte k (bits 8k+7..8k) is the index for data word k+1. The writes of a packet leave the port in slot order 0, 1, 2, 3, and each one carries its own data word unchanged.
- R3: An index with bit 7 = 0 writes byte address 0x1C00 + 4 × (index bits 6..0). These addresses lie in 0x1C00..0x1DFF.
- R4: An index with bit 7 = 1 writes byte address 0x2C00 + 4 × (index bits 6..0). These addresses lie in 0x2C00..0x2DFF.
- R5: Index 0x15 is the filler index, and it addresses 0x1C54. Its data word is consumed but no write is presented. Index 0x95, which addresses 0x2C54, is an ordinary write.
- R6: While a presented write is not accepted (wr_valid=1, wr_ready=0), in_ready is 0. No input word is lost or duplicated.
- R7: Once wr_valid is 1, wr_valid, wr_addr and wr_data hold their values until the cycle in which wr_ready is 1.
- R8: A synchronous active-low reset discards any partial packet. After reset the first accepted word is a header, and wr_valid is 0.
- R9: idle is 1 exactly when the parser waits for a header and no write is pending. It is 1 after reset and 0 from the cycle after a header is accepted.
- R10: When wr_ready is held at 1, the block accepts one word per cycle, so a packet takes five cycles. A data word accepted on a clock edge shows up as a write right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block takes the offered word |
| in_word | input | 32 | Header or data word |
| wr_valid | output | 1 | A register write is presented |
| wr_ready | input | 1 | The register file takes the write |
| wr_addr | output | 14 | Byte address of the write |
| wr_data | output | 32 | Write data |
| idle | output | 1 | Between packets with no pending write |

## Verification
Suppose the slot counter or the header/data phase drifts by one. Then the next packet's header comes out as a write, or its data goes to the wrong address. The bench sees this on the first write after the slip, because it checks every write against a queue of expected address and data pairs.

A filler slot that is not dropped shows up at once as an extra write. An output register that changes while stalled shows up in the next stalled cycle. A reset that leaves the phase in place corrupts the first packet after reset.

// File: rtl/regpkt_pkg.sv
package regpkt_pkg;
    localparam int unsigned WORD_W_DEF   = 32;
    localparam int unsigned IDX_W_DEF    = 8;
    localparam int unsigned SLOTS_DEF    = 4;
    localparam int unsigned ADDR_W_DEF   = 14;
    localparam logic [13:0] BANK_LO_BASE = 14'h1C00;
    localparam logic [13:0] BANK_HI_BASE = 14'h2C00;
    localparam logic [7:0]  FILLER_IDX   = 8'h15;

    typedef enum logic {
        PH_HEADER = 1'b0,
        PH_DATA   = 1'b1
    } phase_e;
endpackage

// File: rtl/regpkt_addr_decode.sv
module regpkt_addr_decode #(
    parameter int unsigned      IDX_W   = 8,
    parameter int unsigned      ADDR_W  = 14,
    parameter logic [ADDR_W-1:0] LO_BASE = 14'h1C00,
    parameter logic [ADDR_W-1:0] HI_BASE = 14'h2C00,
    parameter logic [IDX_W-1:0]  PAD_IDX = 8'h15
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              is_pad
);
    localparam int unsigned OFS_W = IDX_W - 1;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        base   = idx[IDX_W-1] ? HI_BASE : LO_BASE;
        offset = '0;
        offset[OFS_W+1:2] = idx[OFS_W-1:0];
        addr   = base + offset;
        is_pad = (idx == PAD_IDX);
    end
endmodule

// File: rtl/regpkt_wr_stage.sv
module regpkt_wr_stage #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic              can_load,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = load_addr;
            st_d.data  = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign can_load  = !st_q.valid || out_ready;
    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;
    assign out_data  = st_q.data;

    // R7: a stalled write keeps its contents
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

    // R6: the parser never loads into a stalled stage
    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready));
endmodule

// File: rtl/regpkt_unpacker.sv
module regpkt_unpacker
    import regpkt_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned IDX_W  = IDX_W_DEF,
    parameter int unsigned SLOTS  = SLOTS_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              idle
);
    localparam int unsigned HDR_W  = SLOTS * IDX_W;
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        phase_e             phase;
        logic [SLOT_W-1:0]  slot;
        logic [HDR_W-1:0]   hdr;
    } parse_t;

    parse_t ps_d, ps_q;

    logic [ADDR_W-1:0] slot_addr [SLOTS];
    logic [SLOTS-1:0]  slot_pad;
    logic              stage_free;
    logic              accept;
    logic              load;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_pad;

    // every header byte is decoded in parallel; the slot counter picks one
    for (genvar k = 0; k < SLOTS; k++) begin : g_dec
        regpkt_addr_decode #(
            .IDX_W   (IDX_W),
            .ADDR_W  (ADDR_W),
            .LO_BASE (ADDR_W'(BANK_LO_BASE)),
            .HI_BASE (ADDR_W'(BANK_HI_BASE)),
            .PAD_IDX (IDX_W'(FILLER_IDX))
        ) u_dec (
            .idx    (ps_q.hdr[k*IDX_W +: IDX_W]),
            .addr   (slot_addr[k]),
            .is_pad (slot_pad[k])
        );
    end

    always_comb begin
        sel_addr = slot_addr[0];
        sel_pad  = slot_pad[0];
        for (int k = 0; k < SLOTS; k++) begin
            if (ps_q.slot == SLOT_W'(k)) begin
                sel_addr = slot_addr[k];
                sel_pad  = slot_pad[k];
            end
        end
    end

    assign in_ready = stage_free;
    assign accept   = in_valid && in_ready;

    always_comb begin
        ps_d = ps_q;
        load = 1'b0;
        if (accept) begin
            if (ps_q.phase == PH_HEADER) begin
                ps_d.hdr   = ps_q.hdr;
                ps_d.hdr   = in_word[HDR_W-1:0];
                ps_d.slot  = '0;
                ps_d.phase = PH_DATA;
            end else begin
                load = !sel_pad;
                if (ps_q.slot == LAST_SLOT) begin
                    ps_d.slot  = '0;
                    ps_d.phase = PH_HEADER;
                end else begin
                    ps_d.slot = ps_q.slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '{phase: PH_HEADER, slot: '0, hdr: '0};
        end else begin
            ps_q <= ps_d;
        end
    end

    regpkt_wr_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (WORD_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (sel_addr),
        .load_data (in_word),
        .can_load  (stage_free),
        .out_valid (wr_valid),
        .out_ready (wr_ready),
        .out_addr  (wr_addr),
        .out_data  (wr_data)
    );

    assign idle = (ps_q.phase == PH_HEADER) && !wr_valid;

    // R3 / R4: every presented address falls in one of the two windows
    assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00) &&
                     ((wr_addr >= ADDR_W'(BANK_LO_BASE) && wr_addr <= ADDR_W'(BANK_LO_BASE) + ADDR_W'(511)) ||
                      (wr_addr >= ADDR_W'(BANK_HI_BASE) && wr_addr <= ADDR_W'(BANK_HI_BASE) + ADDR_W'(511))));

    // R5: the filler address never reaches the port
    assert_no_filler_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr != ADDR_W'(BANK_LO_BASE) + ADDR_W'({FILLER_IDX[6:0], 2'b00})));

    // R6: input is held back while the port is stalled
    assert_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !in_ready);

    // R9: a header accepted makes the block busy on the next cycle
    assert_busy_after_hdr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idle) |=> !idle);

    // R1: the header phase is left only by an accepted word
    assert_phase_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(ps_q.phase));
endmodule

// File: tb/regpkt_unpacker_tb_top.sv
module regpkt_unpacker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [13:0] wr_addr;
    logic [31:0] wr_data;
    logic        idle;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ready_mode = 0;
    logic [13:0] q_addr [0:255];
    logic [31:0] q_data [0:255];
    int q_push = 0;
    int q_pop  = 0;
    logic        prev_stall = 1'b0;
    logic [13:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    logic        done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    regpkt_unpacker dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .idle(idle)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [13:0] idx_to_addr(input logic [7:0] idx);
        return (idx[7] ? 14'h2C00 : 14'h1C00) + {5'd0, idx[6:0], 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // port monitor: drives wr_ready and compares every accepted write
    always @(negedge clk) begin
        case (ready_mode)
            1:       wr_ready = cyc[0];
            2:       wr_ready = (cyc % 4 == 3);
            default: wr_ready = 1'b1;
        endcase
        #1;
        if (rst_n) begin
            if (prev_stall)
                check(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R7",
                      $sformatf("held %h/%h expected %h/%h", wr_addr, wr_data, prev_addr, prev_data));
            if (wr_valid && !wr_ready)
                check(!in_ready, "R6", $sformatf("in_ready %0b expected 0", in_ready));
            if (wr_valid && wr_ready) begin
                if (q_pop < q_push) begin
                    check(wr_addr == q_addr[q_pop] && wr_data == q_data[q_pop], "R2",
                          $sformatf("write %h/%h expected %h/%h", wr_addr, wr_data,
                                    q_addr[q_pop], q_data[q_pop]));
                    q_pop++;
                end else begin
                    check(1'b0, "R5", $sformatf("write %h/%h expected none", wr_addr, wr_data));
                end
            end
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send_word(input logic [31:0] w);
        bit acc;
        in_valid = 1'b1;
        in_word  = w;
        do begin
            #1 acc = in_ready;
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic expect_wr(input logic [7:0] idx, input logic [31:0] d);
        if (idx != 8'h15) begin
            q_addr[q_push] = idx_to_addr(idx);
            q_data[q_push] = d;
            q_push++;
        end
    endtask

    task automatic send_pkt(input logic [7:0] i0, i1, i2, i3,
                            input logic [31:0] d0, d1, d2, d3);
        expect_wr(i0, d0); expect_wr(i1, d1); expect_wr(i2, d2); expect_wr(i3, d3);
        send_word({i3, i2, i1, i0});
        send_word(d0); send_word(d1); send_word(d2); send_word(d3);
    endtask

    task automatic drain();
        for (int i = 0; i < 12; i++) @(negedge clk);
        check(q_pop == q_push, "R2", $sformatf("writes seen %0d expected %0d", q_pop, q_push));
        #1 check(idle, "R9", $sformatf("idle %0b expected 1", idle));
    endtask

    task automatic t_reset_state();
        #1 check(!wr_valid && idle, "R8",
                 $sformatf("after reset wr_valid %0b idle %0b expected 0 1", wr_valid, idle));
        check(in_ready, "R6", $sformatf("in_ready %0b expected 1", in_ready));
    endtask

    task automatic t_bank_lo();
        ready_mode = 0;
        send_pkt(8'h00, 8'h01, 8'h7F, 8'h20, 32'hA000_0001, 32'hA000_0002, 32'hA000_0003, 32'hA000_0004);
        drain();   // R3
    endtask

    task automatic t_bank_mixed();
        ready_mode = 0;
        send_pkt(8'h80, 8'h05, 8'hFF, 8'h95, 32'hB1, 32'hB2, 32'hB3, 32'hB4);
        drain();   // R4, and 0x95 not filler (R5)
    endtask

    task automatic t_filler();
        ready_mode = 0;
        send_pkt(8'h15, 8'h10, 8'h15, 8'h15, 32'hDEAD_0000, 32'hC0DE_0001, 32'hDEAD_0002, 32'hDEAD_0003);
        send_pkt(8'h15, 8'h15, 8'h15, 8'h15, 32'h1, 32'h2, 32'h3, 32'h4);
        send_pkt(8'h02, 8'h15, 8'h83, 8'h15, 32'h11, 32'h12, 32'h13, 32'h14);
        drain();   // R5 and R1 alignment after filler packets
    endtask

    task automatic t_backpressure();
        for (int m = 1; m <= 2; m++) begin
            ready_mode = m;
            send_pkt(8'h01, 8'h81, 8'h02, 8'h82, 32'h100 + m, 32'h200 + m, 32'h300 + m, 32'h400 + m);
            send_pkt(8'h40, 8'hC0, 8'h15, 8'h3F, 32'h500 + m, 32'h600 + m, 32'h700 + m, 32'h800 + m);
            drain();   // R6 R7
        end
        ready_mode = 0;
    endtask

    task automatic t_throughput();
        int t0;
        ready_mode = 0;
        @(negedge clk);
        t0 = cyc;
        expect_wr(8'h09, 32'h5555); expect_wr(8'h89, 32'h6666);
        expect_wr(8'h0A, 32'h7777); expect_wr(8'h8A, 32'h8888);
        send_word({8'h8A, 8'h0A, 8'h89, 8'h09});
        send_word(32'h5555);
        check(wr_valid && wr_addr == 14'h1C24 && wr_data == 32'h5555, "R10",
              $sformatf("first write %0b %h/%h expected 1 1c24/5555", wr_valid, wr_addr, wr_data));
        send_word(32'h6666); send_word(32'h7777); send_word(32'h8888);
        check(cyc - t0 == 5, "R10", $sformatf("packet cycles %0d expected 5", cyc - t0));
        drain();
    endtask

    task automatic t_idle();
        ready_mode = 0;
        expect_wr(8'h03, 32'hE1); expect_wr(8'h04, 32'hE2);
        expect_wr(8'h05, 32'hE3); expect_wr(8'h06, 32'hE4);
        send_word({8'h06, 8'h05, 8'h04, 8'h03});
        #1 check(!idle, "R9", $sformatf("idle %0b after header expected 0", idle));
        send_word(32'hE1); send_word(32'hE2); send_word(32'hE3); send_word(32'hE4);
        drain();
    endtask

    task automatic t_reset_mid();
        ready_mode = 0;
        expect_wr(8'h11, 32'hF1); expect_wr(8'h12, 32'hF2);
        send_word({8'h14, 8'h13, 8'h12, 8'h11});
        send_word(32'hF1); send_word(32'hF2);
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1 check(idle && !wr_valid, "R8", $sformatf("idle %0b wr_valid %0b expected 1 0", idle, wr_valid));
        send_pkt(8'h21, 8'hA2, 8'h23, 8'hA4, 32'hF5, 32'hF6, 32'hF7, 32'hF8);
        drain();   // R8 R1
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not finish expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_bank_lo();
        t_bank_mixed();
        t_filler();
        t_backpressure();
        t_throughput();
        t_idle();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule